// File: doc/BRIEF.md
# Asynchronous Fault Status Capture Unit

This unit logs memory-system error events for later inspection by software. Each event arrives as a one-cycle pulse that names one of nineteen sticky status flags and a severity class. It carries the faulting address, a 9-bit data ECC syndrome and a 4-bit tag ECC syndrome. Flags accumulate until software clears them with a write-one-to-clear store. A single fault address register and one pair of syndrome fields hold the details of the most severe event logged. They stay locked on that event until software clears that event's own flag.

The unit also keeps a repeat flag for severe errors and a snapshot of the privilege mode. It drops duplicate ECC reports inside one burst transfer. It drives an error pin for protocol and internal failures, and a disrupting-trap request that is gated by the global interrupt enable. Software reads the 64-bit status word or the address register through a combinational read port selected by `rd_sel`.

Severity classes are encoded as 0 hardware-corrected, 1 software-correctable, 2 uncorrectable and 3 protocol/internal. Capture priority rises with the class code.

Top module: `fault_status_log`

## Requirements
- R1: An accepted event with index i (0 to 18) sets status bit 33+i. The bit stays set until a write with bit 33+i equal to 1. An event with index 19 or above is ignored.
- R2: A write clears each of status bits 53 to 33 where the written data has a 1, and changes nothing else. The syndrome fields (bits 19:16 and 8:0), the address register and all other status bits are unaffected by writes. Reads have no side effects. The status word reads 0 in bits 63:54, 32:20 and 15:9.
- R3: Status bit 53 (repeat flag) is set when a class 1 or class 2 event is accepted while its own status bit is already set and is not being cleared in that cycle. A repeat of class 0 or class 3 never sets it.
- R4: An event with `evt_xfer`=1 belongs to the current burst. After the first such event of a burst is accepted, later `evt_xfer` events are ignored until `xfer_start`. An event in the same cycle as `xfer_start` is the first of the new burst.
- R5: Status bit 52 takes the value of `priv_in` on every accepted event.
- R6: When no capture is locked, an accepted event loads the address register and locks it. While locked, only an event of strictly higher class overwrites it. An equal or lower class leaves it unchanged.
- R7: The lock is released in the cycle its owning status bit is cleared, even if other bits remain set. An event in that same cycle may capture.
- R8: The data syndrome (bits 8:0) and tag syndrome (bits 19:16) are loaded together with the address under the R6 and R7 rules. They keep their contents after unlocking until the next capture.
- R9: `err_pin` is high while status bit 51 or bit 50 is set.
- R10: `trap_req` is high while `int_en` is 1 and any status bit selected by TRAP_MASK (bit k selects bit 33+k) is set. It is low whenever `int_en` is 0.
- R11: After reset all status bits, the address and the syndromes read 0, the capture is unlocked, and `err_pin` and `trap_req` are low.
- R12: When an event sets a bit and a write clears the same bit in one cycle, the bit ends up set. The same holds for bits 53 and 52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event pulse |
| evt_cls | input | 2 | Severity class of the event |
| evt_idx | input | 5 | Status flag index (bit 33+index) |
| evt_addr | input | AW | Faulting address |
| evt_dsyn | input | 9 | Data ECC syndrome |
| evt_tsyn | input | 4 | Tag ECC syndrome |
| evt_xfer | input | 1 | Event is an ECC error inside the current burst |
| xfer_start | input | 1 | A new burst begins this cycle |
| priv_in | input | 1 | Current privilege mode |
| wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| wr_data | input | 64 | Write data |
| rd_sel | input | 1 | Read select: 0 status word, 1 fault address |
| int_en | input | 1 | Global interrupt enable |
| rd_data | output | 64 | Read data |
| err_pin | output | 1 | External error indication |
| trap_req | output | 1 | Disrupting-trap request |

## Verification
The hardest situation to reach is the release of a locked capture while other flags stay set, followed by a lower-class event that must now win the capture. Random stimulus rarely clears exactly the owning flag. A directed sequence therefore builds a ladder of classes 0, 1 and 2, clears only the class 2 flag, and then sends a class 0 event. The same-cycle clear-and-set race and the burst de-duplication window are also driven on purpose. Long random runs then mix sparse clear masks with bursts and events of every class.

// File: rtl/fault_status_log.sv
module fault_status_log #(
  parameter int AW = 40,
  parameter logic [18:0] TRAP_MASK = 19'h7FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [1:0]    evt_cls,
  input  logic [4:0]    evt_idx,
  input  logic [AW-1:0] evt_addr,
  input  logic [8:0]    evt_dsyn,
  input  logic [3:0]    evt_tsyn,
  input  logic          evt_xfer,
  input  logic          xfer_start,
  input  logic          priv_in,
  input  logic          wr_en,
  input  logic [63:0]   wr_data,
  input  logic          rd_sel,
  input  logic          int_en,
  output logic [63:0]   rd_data,
  output logic          err_pin,
  output logic          trap_req
);
  localparam int NS = 19;
  localparam int LO = 33;

  logic [NS-1:0] stk;
  logic          me, prv, lk, xhit;
  logic [4:0]    lk_idx;
  logic [1:0]    lk_cls;
  logic [AW-1:0] addr_q;
  logic [8:0]    dsyn_q;
  logic [3:0]    tsyn_q;

  wire [NS-1:0] clr    = wr_en ? wr_data[LO +: NS] : '0;
  wire          acc    = evt_valid && (evt_idx < 5'(NS)) && !(evt_xfer && xhit && !xfer_start);
  wire [NS-1:0] hit    = acc ? ({{(NS-1){1'b0}}, 1'b1} << evt_idx) : '0;
  wire          sev    = (evt_cls == 2'd1) || (evt_cls == 2'd2);
  wire          rpt    = acc && sev && |(hit & stk & ~clr);
  wire          unlock = lk && clr[lk_idx];
  wire          take   = acc && (!lk || unlock || (evt_cls > lk_cls));
  wire          unused_wr = ^{wr_data[63:54], wr_data[32:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk    <= '0;
      me     <= 1'b0;
      prv    <= 1'b0;
      lk     <= 1'b0;
      lk_idx <= '0;
      lk_cls <= '0;
      addr_q <= '0;
      dsyn_q <= '0;
      tsyn_q <= '0;
      xhit   <= 1'b0;
    end else begin
      stk <= (stk & ~clr) | hit;
      if (rpt) me <= 1'b1;
      else if (wr_en && wr_data[53]) me <= 1'b0;
      if (acc) prv <= priv_in;
      else if (wr_en && wr_data[52]) prv <= 1'b0;
      if (take) begin
        lk     <= 1'b1;
        lk_idx <= evt_idx;
        lk_cls <= evt_cls;
        addr_q <= evt_addr;
        dsyn_q <= evt_dsyn;
        tsyn_q <= evt_tsyn;
      end else if (unlock) begin
        lk <= 1'b0;
      end
      if (xfer_start) xhit <= acc && evt_xfer;
      else if (acc && evt_xfer) xhit <= 1'b1;
    end
  end

  assign rd_data  = rd_sel ? {{(64-AW){1'b0}}, addr_q}
                           : {10'd0, me, prv, stk, 13'd0, tsyn_q, 7'd0, dsyn_q};
  assign err_pin  = stk[18] | stk[17];
  assign trap_req = int_en && |(stk & TRAP_MASK);
endmodule

module fault_status_log_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_valid,
  input logic [1:0]    evt_cls,
  input logic [4:0]    evt_idx,
  input logic          evt_xfer,
  input logic          wr_en,
  input logic [63:0]   wr_data,
  input logic          int_en,
  input logic          err_pin,
  input logic          trap_req,
  input logic [18:0]   stk,
  input logic          me,
  input logic          lk,
  input logic [AW-1:0] addr_q
);
  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stk) & ~($past(wr_en) ? $past(wr_data[51:33]) : 19'd0)) & ~stk) == 19'd0));

  // R3
  repeat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_xfer && !wr_en && evt_cls == 2'd2 && evt_idx < 5'd19 &&
     ((stk >> evt_idx) & 19'd1) != 19'd0) |=> me);

  // R6
  addr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk && !evt_valid && !wr_en) |=> $stable(addr_q));

  // R9
  err_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_xfer && evt_idx == 5'd18) |=> err_pin);

  // R10
  trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !trap_req);
endmodule

bind fault_status_log fault_status_log_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cls(evt_cls),
  .evt_idx(evt_idx), .evt_xfer(evt_xfer), .wr_en(wr_en), .wr_data(wr_data),
  .int_en(int_en), .err_pin(err_pin), .trap_req(trap_req), .stk(stk),
  .me(me), .lk(lk), .addr_q(addr_q)
);

// File: tb/fault_status_log_test.sv
module fault_status_log_test;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic [1:0]    evt_cls = '0;
  logic [4:0]    evt_idx = '0;
  logic [AW-1:0] evt_addr = '0;
  logic [8:0]    evt_dsyn = '0;
  logic [3:0]    evt_tsyn = '0;
  logic          evt_xfer = 1'b0;
  logic          xfer_start = 1'b0;
  logic          priv_in = 1'b0;
  logic          wr_en = 1'b0;
  logic [63:0]   wr_data = '0;
  logic          rd_sel = 1'b0;
  logic          int_en = 1'b0;
  logic [63:0]   rd_data;
  logic          err_pin, trap_req;

  fault_status_log #(.AW(AW)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  logic [18:0]   m_st;
  logic          m_me, m_prv, m_lk, m_xhit;
  logic [4:0]    m_lki;
  logic [1:0]    m_lkc;
  logic [AW-1:0] m_addr;
  logic [8:0]    m_ds;
  logic [3:0]    m_ts;

  task automatic m_reset();
    m_st = '0; m_me = 0; m_prv = 0; m_lk = 0; m_xhit = 0;
    m_lki = '0; m_lkc = '0; m_addr = '0; m_ds = '0; m_ts = '0;
  endtask

  task automatic m_step();
    logic ok, rel, cap;
    logic [18:0] cm;
    if (!rst_n) begin m_reset(); return; end
    cm  = wr_en ? wr_data[51:33] : 19'd0;
    ok  = evt_valid && evt_idx <= 5'd18;
    if (evt_xfer && m_xhit && !xfer_start) ok = 0;
    rel = m_lk && cm[m_lki];
    cap = ok && (!m_lk || rel || evt_cls > m_lkc);
    if (ok && (evt_cls == 2'd1 || evt_cls == 2'd2) && m_st[evt_idx] && !cm[evt_idx]) m_me = 1;
    else if (wr_en && wr_data[53]) m_me = 0;
    if (ok) m_prv = priv_in;
    else if (wr_en && wr_data[52]) m_prv = 0;
    m_st = m_st & ~cm;
    if (ok) m_st[evt_idx] = 1'b1;
    if (cap) begin
      m_lk = 1; m_lki = evt_idx; m_lkc = evt_cls;
      m_addr = evt_addr; m_ds = evt_dsyn; m_ts = evt_tsyn;
    end else if (rel) m_lk = 0;
    if (xfer_start) m_xhit = ok && evt_xfer;
    else if (ok && evt_xfer) m_xhit = 1;
  endtask

  function automatic logic [63:0] exp_status();
    return {10'd0, m_me, m_prv, m_st, 13'd0, m_ts, 7'd0, m_ds};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] s, e;
    rd_sel = 1'b0; #1;
    s = rd_data; e = exp_status();
    chk("R1 sticky", 64'(s[51:33]), 64'(e[51:33]));
    chk("R3 repeat", 64'(s[53]), 64'(e[53]));
    chk("R5 priv", 64'(s[52]), 64'(e[52]));
    chk("R8 syndromes", 64'({s[19:16], s[8:0]}), 64'({e[19:16], e[8:0]}));
    chk("R2 reserved zero", {s[63:54], s[32:20], s[15:9]} == '0 ? 64'd0 : 64'd1, 64'd0);
    rd_sel = 1'b1; #1;
    chk("R6 address", rd_data, 64'(m_addr));
    chk("R9 err_pin", 64'(err_pin), 64'(m_st[18] | m_st[17]));
    chk("R10 trap", 64'(trap_req), 64'(int_en && (m_st != 0)));
  endtask

  task automatic cycle();
    @(posedge clk);
    m_step();
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic idle();
    evt_valid = 0; evt_xfer = 0; xfer_start = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic ev(input logic [1:0] c, input logic [4:0] i, input logic [AW-1:0] a,
                    input logic xf, input logic xs);
    evt_valid = 1; evt_cls = c; evt_idx = i; evt_addr = a;
    evt_dsyn = 9'(a); evt_tsyn = 4'(a >> 9); evt_xfer = xf; xfer_start = xs;
    cycle(); idle();
  endtask

  task automatic wclr(input logic [63:0] d);
    wr_en = 1; wr_data = d; cycle(); idle();
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    @(negedge clk);
    repeat (3) cycle();
    rst_n = 1'b1; int_en = 1'b1;
    // R11 reset state
    rd_sel = 0; #1; chk("R11 status", rd_data, 64'd0);
    rd_sel = 1; #1; chk("R11 address", rd_data, 64'd0);
    chk("R11 pins", 64'({err_pin, trap_req}), 64'd0);
    @(negedge clk);

    // R3: hardware-corrected repeat leaves repeat flag clear
    ev(2'd0, 5'd0, 40'h11_0000_0111, 0, 0);
    ev(2'd0, 5'd0, 40'h11_0000_0222, 0, 0);
    // R6: higher class overwrites; R3 software-correctable repeat
    ev(2'd1, 5'd9, 40'h22_0000_0333, 0, 0);
    ev(2'd1, 5'd9, 40'h22_0000_0444, 0, 0);
    ev(2'd2, 5'd1, 40'h33_0000_0555, 0, 0);
    ev(2'd1, 5'd5, 40'h44_0000_0666, 0, 0);
    ev(2'd2, 5'd7, 40'h44_0000_0777, 0, 0);
    // R7, R8: clear owner bit only, syndromes kept, then lower class captures
    wclr(64'h1 << 34);
    ev(2'd0, 5'd3, 40'h55_0000_0888, 0, 0);
    // R12: clear and set same bit in one cycle
    priv_in = 1;
    evt_valid = 1; evt_cls = 2'd0; evt_idx = 5'd4; evt_addr = 40'h66;
    wr_en = 1; wr_data = (64'h1 << 37) | (64'h3 << 52); cycle(); idle();
    priv_in = 0;
    // R4: burst de-duplication
    ev(2'd2, 5'd2, 40'h77_0000_0999, 1, 1);
    ev(2'd2, 5'd6, 40'h77_0000_0aaa, 1, 0);
    ev(2'd2, 5'd6, 40'h77_0000_0bbb, 1, 1);
    // R1: out-of-range index ignored
    ev(2'd3, 5'd25, 40'h88, 0, 0);
    // R9: protocol error drives pin
    ev(2'd3, 5'd18, 40'h99_0000_0ccc, 0, 0);
    wclr(64'h1 << 51);
    ev(2'd3, 5'd17, 40'h99_0000_0ddd, 0, 0);
    // R10: trap gated by enable
    int_en = 0; cycle();
    int_en = 1; cycle();
    // R2: clear everything writable, syndromes and address stay
    wclr('1);
    rd_sel = 0; cycle();

    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 2 == 0) begin
        evt_valid = 1;
        evt_cls = 2'($urandom % 4);
        evt_idx = 5'($urandom % 21);
        evt_addr = {8'($urandom), 32'($urandom)};
        evt_dsyn = 9'($urandom); evt_tsyn = 4'($urandom);
        evt_xfer = ($urandom % 3 == 0);
      end
      xfer_start = ($urandom % 6 == 0);
      priv_in = 1'($urandom);
      if ($urandom % 8 == 0) begin
        wr_en = 1;
        wr_data = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      end
      if ($urandom % 16 == 0) int_en = ~int_en;
      cycle();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule